// File: doc/BRIEF.md
# ADC Instance Register Block with Power Sequencing

This block is the register-level model of one analog-to-digital converter instance. It sits on a plain memory-mapped bus with byte address, 32-bit write data, write and read strobes, and combinational read data. Software uses it to bring the converter out of deep power-down, to turn on and wait for the voltage regulator, to enable the converter and wait for readiness, to set up the sample-time, channel-preselect, sequence and differential-select registers, and to launch single software-started conversions whose result is then read from the data register.

The analog converter is not part of the block. The sampled value comes from the `sample_in` port and is captured when a conversion finishes. The conversion length in clock cycles comes from the `conv_cycles` port. The startup delays of the regulator and of the converter are parameters. Interlocks keep the power states consistent: deep power-down forces the regulator enable off, the ready flags drop as soon as what they depend on goes away, and a conversion stops if readiness is lost.

Top module: `adc_regblock`

## Requirements
- R1: After reset the control register (offset 0x08) reads 0x2000_0000, with only deep power-down (bit 29) set. Status (0x00), data (0x40) and every configuration register read 0.
- R2: The writable registers read back through these masks: configuration 0x0C mask 0x0000_0C03 (trigger edge [11:10], data management [1:0]), sample-time 0x14 and 0x18 full 32 bits, preselect 0x1C and differential select 0xC0 mask 0x000F_FFFF (channels 0 to 19), sequence 0x30 mask 0x0000_07CF (length [3:0], first channel [10:6]). Control bit 8 (boost) is stored.
- R3: Reads of any unmapped or misaligned address return 0 and writes to them change nothing. Writes to status and data are ignored.
- R4: A control write with bit 29 set stores deep power-down and clears the regulator enable (bit 28) in the same write, even when bit 28 is written as 1. Regulator ready (status bit 12) and ready (status bit 0) then read 0 at once.
- R5: Regulator ready reads 1 starting VREG_DLY clock edges after the edge that stores regulator enable = 1 with deep power-down = 0. It stays 0 while either condition is missing.
- R6: Ready (status bit 0) reads 1 after the enable bit (control bit 0) has been 1 while regulator ready was 1 for RDY_DLY edges. It never reads 1 unless both are 1.
- R7: A control write with bit 1 set clears enable and ready. Bit 1 always reads 0.
- R8: A control write with bit 2 set starts a conversion only when ready is 1 and the trigger-edge field is 0. Otherwise bit 2 stays 0, no end of conversion occurs and the data register is unchanged.
- R9: An accepted conversion keeps control bit 2 at 1 for max(conv_cycles,1) edges. It then sets end of conversion (status bit 2), loads `sample_in` into data [15:0] and clears bit 2. Losing ready aborts it without setting end of conversion.
- R10: A read of the data register clears end of conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a data read clears end of conversion |
| bus_rdata | output | 32 | Read data, combinational from address |
| sample_in | input | 16 | Sample value captured when a conversion completes |
| conv_cycles | input | 8 | Conversion length in cycles (0 acts as 1) |

## Verification
The power sequence is swept cycle by cycle after each enabling write, with status read on every cycle. This pins the exact edge at which regulator ready and ready rise, including the case where ready has to wait for the regulator first. Conversions are swept over latencies 0 to 5 with a different sample each time, so an off-by-one in the countdown or a wrong capture edge shows up as a wrong edge for end of conversion or a wrong data word. Every aligned offset in the address space is written with all ones and read back to separate mapped from unmapped decode. Rejected starts (not ready, trigger field set) and an abort by deep power-down are checked by the absence of end of conversion and an unchanged data word.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SMP1  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SMP2  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PSEL  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SEQ1  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_DSEL  = 8'hC0;

    // control bit positions
    localparam int CB_EN     = 0;
    localparam int CB_DIS    = 1;
    localparam int CB_START  = 2;
    localparam int CB_BOOST  = 8;
    localparam int CB_VREGEN = 28;
    localparam int CB_PWRDN  = 29;

    // status bit positions
    localparam int SB_RDY  = 0;
    localparam int SB_EOC  = 2;
    localparam int SB_VRDY = 12;

    // field positions
    localparam int SEQ_CH1_LSB = 6;
    localparam int SEQ_LEN_W   = 4;
endpackage

// File: rtl/adc_delay_timer.sv
module adc_delay_timer #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DLY);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == LIMIT);

    always_comb begin
        if (!run_i)      cnt_d = '0;
        else if (done_o) cnt_d = cnt_q;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             busy_o,
    output logic             fin_o
);
    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
    } conv_t;

    conv_t st_d, st_q;

    assign busy_o = st_q.busy;
    assign fin_o  = st_q.busy && !abort_i && (st_q.cnt <= LAT_W'(1));

    always_comb begin
        st_d = st_q;
        if (abort_i) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (start_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = (lat_i == '0) ? LAT_W'(1) : lat_i;
        end else if (fin_o) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adc_regblock.sv
module adc_regblock
    import adc_regs_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NUM_CH   = 20,
    parameter int LAT_W    = 8,
    parameter int VREG_DLY = 6,
    parameter int RDY_DLY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [LAT_W-1:0]  conv_cycles
);
    localparam int CHW = $clog2(NUM_CH);

    typedef struct packed {
        logic                 pwrdn;
        logic                 vregen;
        logic                 boost;
        logic                 en;
        logic [1:0]           trig;
        logic [1:0]           dmgt;
        logic [REG_W-1:0]     smp1;
        logic [REG_W-1:0]     smp2;
        logic [NUM_CH-1:0]    presel;
        logic [NUM_CH-1:0]    difsel;
        logic [SEQ_LEN_W-1:0] seq_len;
        logic [CHW-1:0]       seq_ch1;
        logic                 eoc;
        logic [SAMPLE_W-1:0]  dout;
    } regs_t;

    regs_t r_d, r_q;

    logic vreg_done, rdy_done;
    logic vrdy, rdy;
    logic conv_busy, conv_fin, start_req, wr_ctrl;

    // state views for the bound checker
    logic                st_pwrdn, st_vregen, st_en, st_eoc;
    logic [1:0]          st_trig;
    logic [SAMPLE_W-1:0] st_dout;
    assign st_pwrdn  = r_q.pwrdn;
    assign st_vregen = r_q.vregen;
    assign st_en     = r_q.en;
    assign st_eoc    = r_q.eoc;
    assign st_trig   = r_q.trig;
    assign st_dout   = r_q.dout;

    adc_delay_timer #(.DLY(VREG_DLY)) vreg_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (r_q.vregen && !r_q.pwrdn),
        .done_o(vreg_done)
    );

    assign vrdy = vreg_done && r_q.vregen && !r_q.pwrdn;

    adc_delay_timer #(.DLY(RDY_DLY)) rdy_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (r_q.en && vrdy),
        .done_o(rdy_done)
    );

    assign rdy = rdy_done && r_q.en && vrdy;

    assign wr_ctrl   = bus_we && (bus_addr == OFS_CTRL);
    assign start_req = wr_ctrl && bus_wdata[CB_START] && rdy && (r_q.trig == 2'b00);

    adc_conv_ctl #(.LAT_W(LAT_W)) conv_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_req),
        .abort_i(!rdy),
        .lat_i  (conv_cycles),
        .busy_o (conv_busy),
        .fin_o  (conv_fin)
    );

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (bus_addr)
                OFS_CTRL: begin
                    r_d.pwrdn  = bus_wdata[CB_PWRDN];
                    r_d.vregen = bus_wdata[CB_VREGEN] && !bus_wdata[CB_PWRDN];
                    r_d.boost  = bus_wdata[CB_BOOST];
                    r_d.en     = bus_wdata[CB_EN] && !bus_wdata[CB_DIS];
                end
                OFS_CFG: begin
                    r_d.trig = bus_wdata[11:10];
                    r_d.dmgt = bus_wdata[1:0];
                end
                OFS_SMP1: r_d.smp1   = bus_wdata;
                OFS_SMP2: r_d.smp2   = bus_wdata;
                OFS_PSEL: r_d.presel = bus_wdata[NUM_CH-1:0];
                OFS_DSEL: r_d.difsel = bus_wdata[NUM_CH-1:0];
                OFS_SEQ1: begin
                    r_d.seq_len = bus_wdata[SEQ_LEN_W-1:0];
                    r_d.seq_ch1 = bus_wdata[SEQ_CH1_LSB +: CHW];
                end
                default: ;
            endcase
        end
        if (bus_re && (bus_addr == OFS_DATA)) r_d.eoc = 1'b0;
        if (conv_fin) begin
            r_d.eoc  = 1'b1;
            r_d.dout = sample_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.pwrdn <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STAT: begin
                bus_rdata[SB_RDY]  = rdy;
                bus_rdata[SB_EOC]  = r_q.eoc;
                bus_rdata[SB_VRDY] = vrdy;
            end
            OFS_CTRL: begin
                bus_rdata[CB_EN]     = r_q.en;
                bus_rdata[CB_START]  = conv_busy;
                bus_rdata[CB_BOOST]  = r_q.boost;
                bus_rdata[CB_VREGEN] = r_q.vregen;
                bus_rdata[CB_PWRDN]  = r_q.pwrdn;
            end
            OFS_CFG: begin
                bus_rdata[11:10] = r_q.trig;
                bus_rdata[1:0]   = r_q.dmgt;
            end
            OFS_SMP1: bus_rdata = r_q.smp1;
            OFS_SMP2: bus_rdata = r_q.smp2;
            OFS_PSEL: bus_rdata[NUM_CH-1:0] = r_q.presel;
            OFS_DSEL: bus_rdata[NUM_CH-1:0] = r_q.difsel;
            OFS_SEQ1: begin
                bus_rdata[SEQ_LEN_W-1:0]          = r_q.seq_len;
                bus_rdata[SEQ_CH1_LSB +: CHW]     = r_q.seq_ch1;
            end
            OFS_DATA: bus_rdata[SAMPLE_W-1:0] = r_q.dout;
            default: ;
        endcase
    end
endmodule

// File: rtl/adc_regblock_chk.sv
module adc_regblock_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                bus_we,
    input logic                bus_re,
    input logic [31:0]         bus_rdata,
    input logic [SAMPLE_W-1:0] sample_in,
    input logic                st_pwrdn,
    input logic                st_vregen,
    input logic                st_en,
    input logic                st_eoc,
    input logic [1:0]          st_trig,
    input logic [SAMPLE_W-1:0] st_dout,
    input logic                vrdy,
    input logic                rdy,
    input logic                conv_busy,
    input logic                conv_fin
);
    logic hit_map;
    assign hit_map = (bus_addr == 8'h00) || (bus_addr == 8'h08) || (bus_addr == 8'h0C) ||
                     (bus_addr == 8'h14) || (bus_addr == 8'h18) || (bus_addr == 8'h1C) ||
                     (bus_addr == 8'h30) || (bus_addr == 8'h40) || (bus_addr == 8'hC0);

    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !hit_map) |-> (bus_rdata == 32'h0));

    // R4
    pwrdn_kills_vreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h08 && bus_wdata[29]) |=> (st_pwrdn && !st_vregen && !vrdy));

    // R5
    vrdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vrdy) |-> ($past(st_vregen) && !$past(st_pwrdn)));

    // R6
    rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> ($past(st_en) && $past(vrdy)));

    // R7
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h08 && bus_wdata[1]) |=> (!st_en && !rdy));

    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy) |-> ($past(rdy) && $past(st_trig) == 2'b00));

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_fin |=> (st_eoc && st_dout == $past(sample_in) && !conv_busy));

    // R10
    eoc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 8'h40 && !conv_fin) |=> !st_eoc);
endmodule

bind adc_regblock adc_regblock_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_rdata(bus_rdata),
    .sample_in(sample_in),
    .st_pwrdn (st_pwrdn),
    .st_vregen(st_vregen),
    .st_en    (st_en),
    .st_eoc   (st_eoc),
    .st_trig  (st_trig),
    .st_dout  (st_dout),
    .vrdy     (vrdy),
    .rdy      (rdy),
    .conv_busy(conv_busy),
    .conv_fin (conv_fin)
);

// File: tb/adc_regblock_tb_top.sv
module adc_regblock_tb_top;
    localparam int VD = 6;
    localparam int RD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] sample_in = '0;
    logic [7:0]  conv_cycles = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_regblock #(.SAMPLE_W(16), .NUM_CH(20), .LAT_W(8), .VREG_DLY(VD), .RDY_DLY(RD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .sample_in(sample_in), .conv_cycles(conv_cycles)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // each bus operation starts at a falling edge and takes one cycle
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_re = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit mapped(input logic [7:0] a);
        return a == 8'h00 || a == 8'h08 || a == 8'h0C || a == 8'h14 || a == 8'h18 ||
               a == 8'h1C || a == 8'h30 || a == 8'h40 || a == 8'hC0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  offs [6];
        logic [31:0] msks [6];
        logic [31:0] pats [4];
        logic [15:0] last_sample;
        offs = '{8'h0C, 8'h14, 8'h18, 8'h1C, 8'h30, 8'hC0};
        msks = '{32'h0000_0C03, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h000F_FFFF, 32'h0000_07CF, 32'h000F_FFFF};
        pats = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0000_0000};

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rd(8'h08, v); check("R1 ctrl", v, 32'h2000_0000);
        rd(8'h00, v); check("R1 status", v, 32'h0);
        rd(8'h40, v); check("R1 data", v, 32'h0);
        for (int i = 0; i < 6; i++) begin
            rd(offs[i], v); check("R1 cfg regs", v, 32'h0);
        end

        // R2 storage masks
        for (int i = 0; i < 6; i++) begin
            for (int p = 0; p < 4; p++) begin
                wr(offs[i], pats[p]);
                rd(offs[i], v); check("R2 readback", v, pats[p] & msks[i]);
            end
        end
        wr(8'h08, 32'h2000_0100);
        rd(8'h08, v); check("R2 boost", v, 32'h2000_0100);
        wr(8'h08, 32'h2000_0000);
        wr(8'h1C, 32'h0001_2345);

        // R3 unmapped sweep, status/data writes ignored
        for (int a = 0; a < 256; a += 4) begin
            if (!mapped(8'(a))) begin
                wr(8'(a), 32'hFFFF_FFFF);
                rd(8'(a), v); check("R3 unmapped", v, 32'h0);
            end
        end
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R3 status write", v, 32'h0);
        rd(8'h40, v); check("R3 data write", v, 32'h0);
        rd(8'h09, v); check("R3 misaligned", v, 32'h0);
        rd(8'h08, v); check("R3 ctrl intact", v, 32'h2000_0000);
        rd(8'h1C, v); check("R3 presel intact", v, 32'h0001_2345);

        // R5 regulator startup sweep
        wr(8'h08, 32'h1000_0000);
        for (int k = 0; k <= VD + 2; k++) begin
            rd(8'h00, v); check("R5 vreg ready", v, (k >= VD) ? 32'h1000 : 32'h0);
        end

        // R6 enable startup sweep
        wr(8'h08, 32'h1000_0001);
        for (int k = 0; k <= RD + 2; k++) begin
            rd(8'h00, v); check("R6 ready", v, 32'h1000 | ((k >= RD) ? 32'h1 : 32'h0));
        end

        // R9 / R10 conversion latency sweep
        for (int L = 0; L <= 5; L++) begin
            int le;
            le = (L == 0) ? 1 : L;
            conv_cycles = 8'(L);
            sample_in = 16'h1111 * 16'(L + 1) ^ 16'h00F0;
            last_sample = sample_in;
            wr(8'h08, 32'h1000_0005);
            rd(8'h08, v); check("R9 busy", v, 32'h1000_0005);
            for (int k = 1; k <= le + 1; k++) begin
                rd(8'h00, v); check("R9 eoc timing", v, 32'h1001 | ((k >= le) ? 32'h4 : 32'h0));
            end
            sample_in = ~sample_in;
            rd(8'h08, v); check("R9 start cleared", v, 32'h1000_0001);
            rd(8'h40, v); check("R9 data", v, {16'h0, last_sample});
            rd(8'h00, v); check("R10 eoc cleared", v, 32'h1001);
        end

        // R8 start refused with trigger field set
        wr(8'h0C, 32'h0000_0400);
        conv_cycles = 8'd2;
        wr(8'h08, 32'h1000_0005);
        rd(8'h08, v); check("R8 trig refused", v, 32'h1000_0001);
        idle(6);
        rd(8'h00, v); check("R8 no eoc", v, 32'h1001);
        rd(8'h40, v); check("R8 data kept", v, {16'h0, last_sample});
        wr(8'h0C, 32'h0);

        // R7 disable
        wr(8'h08, 32'h1000_0003);
        rd(8'h08, v); check("R7 ctrl", v, 32'h1000_0000);
        rd(8'h00, v); check("R7 status", v, 32'h1000);

        // R8 start refused when not ready
        wr(8'h08, 32'h1000_0004);
        rd(8'h08, v); check("R8 not ready", v, 32'h1000_0000);
        idle(6);
        rd(8'h00, v); check("R8 no eoc idle", v, 32'h1000);

        // R4 deep power-down clears regulator enable
        wr(8'h08, 32'h3000_0001);
        rd(8'h08, v); check("R4 ctrl", v, 32'h2000_0001);
        rd(8'h00, v); check("R4 status", v, 32'h0);
        idle(10);
        rd(8'h00, v); check("R6 no ready without vreg", v, 32'h0);

        // R5 / R6 chained startup
        wr(8'h08, 32'h1000_0001);
        for (int k = 0; k <= VD + RD + 1; k++) begin
            rd(8'h00, v);
            check("R6 chained", v, ((k >= VD) ? 32'h1000 : 32'h0) | ((k >= VD + RD) ? 32'h1 : 32'h0));
        end

        // R9 abort by deep power-down
        conv_cycles = 8'd20;
        sample_in = 16'hBEEF;
        wr(8'h08, 32'h1000_0005);
        idle(3);
        wr(8'h08, 32'h2000_0000);
        idle(1);
        rd(8'h08, v); check("R9 abort ctrl", v, 32'h2000_0000);
        idle(25);
        rd(8'h00, v); check("R9 abort no eoc", v, 32'h0);
        rd(8'h40, v); check("R9 abort data", v, {16'h0, last_sample});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule